// File: doc/BRIEF.md
# PWM Generator with Clock-Rate Select and Switch Routing

This block is an 8-bit pulse-width modulator. A 3-bit rate code selects its input tick from one of two sources: the main (fast) clock divided by 1, 2 or 4, or an asynchronous 32.768 kHz clock. The slow clock is synchronized into the main domain and then divided by 1, 4, 32, 128 or 1024. A period counts 256 ticks. The output is high at the start of each period while the count is below the duty value, and low for the rest of the period. A new duty value is held in a shadow register and takes effect only at the next period boundary.

The PWM output drives three analog-switch control lines, each with a valid flag. Switch A is driven by a pair of select bits. One bit routes the true output and the other routes the inverted output. When the two bits are equal, the PWM has no control of switch A. Each of the two single-pole switch lines has its own enable bit. The `sleep_i` input marks the fast clock as shut down. While it is high, the three fast-derived rates are unavailable. If one of them is selected, the output is forced low and `unavail_o` is raised.

Top module: `pwm_switch_router`

## Requirements
- R1: After reset all configuration fields are 0, and `pwm_o`, `unavail_o`, `swa_o`, `swa_vld_o`, `spdt_o` and `spdt_vld_o` are all 0.
- R2: With the enable field at 0, `pwm_o` stays 0.
- R3: The period, in main-clock cycles, is 256 ticks × the tick spacing. Rate codes 0, 1 and 2 give a tick every 1, 2 and 4 main cycles. Codes 3 to 7 give one tick per 1, 2^S_LOG2_A, 2^S_LOG2_B, 2^S_LOG2_C and 2^S_LOG2_D rising edges of `slow_clk_i`. The defaults for those exponents are 2, 5, 7 and 10.
- R4: Each period starts with `pwm_o` high for `duty` ticks, then low for the rest. Duty 0 gives a constant low, and duty 255 gives 255 high ticks out of 256.
- R5: A duty written in mid-period leaves the current period unchanged and applies from the next period start.
- R6: While `sleep_i` is 1 and a rate code from 0 to 2 is selected with the PWM enabled, `unavail_o` is 1 and `pwm_o` is 0. With `sleep_i` high, codes 3 to 7 keep running.
- R7: With switch-A high select = 1 and low select = 0, `swa_o` equals `pwm_o`. With high select = 0 and low select = 1, `swa_o` equals the inverse of `pwm_o`. When the two selects are equal, `swa_vld_o` is 0 and `swa_o` is 0.
- R8: Bit k of `cfg_spd_i` routes `pwm_o` to `spdt_o[k]` and sets `spdt_vld_o[k]`. A 0 in that bit makes both 0.
- R9: Every valid flag is 0 whenever the enable field is 0, and any output line whose valid flag is 0 is driven 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main (fast) clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slow_clk_i | input | 1 | 32.768 kHz clock, asynchronous to clk_i |
| sleep_i | input | 1 | Fast clock shut down by sleep |
| cfg_we_i | input | 1 | Load all configuration fields |
| cfg_en_i | input | 1 | PWM enable field |
| cfg_fsel_i | input | 3 | Rate code |
| cfg_swa_hi_i | input | 1 | Switch A driven by the true PWM |
| cfg_swa_lo_i | input | 1 | Switch A driven by the inverted PWM |
| cfg_spd_i | input | N_SPDT | Per-line route enable for the single-pole switches |
| cfg_duty_i | input | CNT_W | Duty value |
| pwm_o | output | 1 | PWM output |
| unavail_o | output | 1 | Selected fast rate unavailable in sleep |
| swa_o | output | 1 | Switch A drive |
| swa_vld_o | output | 1 | Switch A is under PWM control |
| spdt_o | output | N_SPDT | Single-pole switch drives |
| spdt_vld_o | output | N_SPDT | Single-pole switches under PWM control |

## Verification
The bench keeps CNT_W at 8 and N_SPDT at 2. It lowers the slow-divider exponents to 1, 2, 3 and 4. With those values, even rate code 7 completes a full 256-tick period within the cycle budget, so the bench can measure the exact period and high time of the slowest slow-clock path. The bench drives the slow clock with a fixed period of six main cycles. This gives every slow-derived period an exact expected length. The fast codes are checked by counting high cycles over whole periods, starting from a known phase after enable.

// File: rtl/pwm_sw_pkg.sv
package pwm_sw_pkg;

  typedef enum logic [2:0] {
    FS_F1 = 3'd0,
    FS_F2 = 3'd1,
    FS_F4 = 3'd2,
    FS_S1 = 3'd3,
    FS_S2 = 3'd4,
    FS_S3 = 3'd5,
    FS_S4 = 3'd6,
    FS_S5 = 3'd7
  } fsel_e;

  typedef struct packed {
    logic  en;
    fsel_e fsel;
    logic  swa_hi;
    logic  swa_lo;
  } pwm_cfg_t;

  function automatic logic fsel_is_fast(fsel_e f);
    return (f == FS_F1) || (f == FS_F2) || (f == FS_F4);
  endfunction

endpackage

// File: rtl/pwm_sw_prescaler.sv
module pwm_sw_prescaler
  import pwm_sw_pkg::*;
#(
  parameter int unsigned S_LOG2_A = 2,
  parameter int unsigned S_LOG2_B = 5,
  parameter int unsigned S_LOG2_C = 7,
  parameter int unsigned S_LOG2_D = 10
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_i,
  input  logic  slow_clk_i,
  input  fsel_e fsel_i,
  output logic  tick_o
);

  localparam int unsigned SLOW_W = S_LOG2_D;
  localparam int unsigned SYNC_N = 3;
  localparam logic [SLOW_W-1:0] MASK_A = SLOW_W'((1 << S_LOG2_A) - 1);
  localparam logic [SLOW_W-1:0] MASK_B = SLOW_W'((1 << S_LOG2_B) - 1);
  localparam logic [SLOW_W-1:0] MASK_C = SLOW_W'((1 << S_LOG2_C) - 1);
  localparam logic [SLOW_W-1:0] MASK_D = SLOW_W'((1 << S_LOG2_D) - 1);

  logic [SYNC_N-1:0] sync_q;
  logic              slow_edge;
  logic [1:0]        fast_q;
  logic [SLOW_W-1:0] slow_q;

  // two flops for metastability, third for edge detect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_N-2:0], slow_clk_i};
  end

  assign slow_edge = sync_q[SYNC_N-2] & ~sync_q[SYNC_N-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fast_q <= '0;
      slow_q <= '0;
    end else if (!run_i) begin
      fast_q <= '0;
      slow_q <= '0;
    end else begin
      fast_q <= fast_q + 2'd1;
      if (slow_edge) slow_q <= slow_q + 1'b1;
    end
  end

  always_comb begin
    unique case (fsel_i)
      FS_F1:   tick_o = 1'b1;
      FS_F2:   tick_o = fast_q[0];
      FS_F4:   tick_o = &fast_q;
      FS_S1:   tick_o = slow_edge;
      FS_S2:   tick_o = slow_edge && ((slow_q & MASK_A) == MASK_A);
      FS_S3:   tick_o = slow_edge && ((slow_q & MASK_B) == MASK_B);
      FS_S4:   tick_o = slow_edge && ((slow_q & MASK_C) == MASK_C);
      default: tick_o = slow_edge && ((slow_q & MASK_D) == MASK_D);
    endcase
    tick_o = tick_o & run_i;
  end

endmodule

// File: rtl/pwm_sw_core.sv
module pwm_sw_core #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] duty_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] duty_q;

  assign wrap_o = run_i & tick_i & (cnt_q == CNT_MAX);

  // shadow duty follows input while idle, then only at period wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      duty_q <= '0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      duty_q <= duty_i;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (wrap_o) duty_q <= duty_i;
    end
  end

  assign pwm_o  = run_i & (cnt_q < duty_q);
  assign cnt_o  = cnt_q;
  assign duty_o = duty_q;

endmodule

// File: rtl/pwm_sw_route.sv
module pwm_sw_route #(
  parameter int unsigned N_SPDT = 2
) (
  input  logic              en_i,
  input  logic              pwm_i,
  input  logic              swa_hi_i,
  input  logic              swa_lo_i,
  input  logic [N_SPDT-1:0] spd_i,
  output logic              swa_o,
  output logic              swa_vld_o,
  output logic [N_SPDT-1:0] spdt_o,
  output logic [N_SPDT-1:0] spdt_vld_o
);

  assign swa_vld_o = en_i & (swa_hi_i ^ swa_lo_i);
  assign swa_o     = swa_vld_o & (swa_hi_i ? pwm_i : ~pwm_i);

  for (genvar g = 0; g < N_SPDT; g++) begin : g_spdt
    assign spdt_vld_o[g] = en_i & spd_i[g];
    assign spdt_o[g]     = spdt_vld_o[g] & pwm_i;
  end

endmodule

// File: rtl/pwm_switch_router.sv
module pwm_switch_router
  import pwm_sw_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned N_SPDT   = 2,
  parameter int unsigned S_LOG2_A = 2,
  parameter int unsigned S_LOG2_B = 5,
  parameter int unsigned S_LOG2_C = 7,
  parameter int unsigned S_LOG2_D = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_clk_i,
  input  logic              sleep_i,
  input  logic              cfg_we_i,
  input  logic              cfg_en_i,
  input  logic [2:0]        cfg_fsel_i,
  input  logic              cfg_swa_hi_i,
  input  logic              cfg_swa_lo_i,
  input  logic [N_SPDT-1:0] cfg_spd_i,
  input  logic [CNT_W-1:0]  cfg_duty_i,
  output logic              pwm_o,
  output logic              unavail_o,
  output logic              swa_o,
  output logic              swa_vld_o,
  output logic [N_SPDT-1:0] spdt_o,
  output logic [N_SPDT-1:0] spdt_vld_o
);

  pwm_cfg_t          cfg_q;
  logic [N_SPDT-1:0] spd_q;
  logic [CNT_W-1:0]  duty_q;
  logic              run_q;
  logic              run;
  logic              tick;
  logic              wrap;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  duty_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      spd_q  <= '0;
      duty_q <= '0;
    end else if (cfg_we_i) begin
      cfg_q.en     <= cfg_en_i;
      cfg_q.fsel   <= fsel_e'(cfg_fsel_i);
      cfg_q.swa_hi <= cfg_swa_hi_i;
      cfg_q.swa_lo <= cfg_swa_lo_i;
      spd_q        <= cfg_spd_i;
      duty_q       <= cfg_duty_i;
    end
  end

  assign unavail_o = sleep_i & cfg_q.en & fsel_is_fast(cfg_q.fsel);

  // one-cycle delay lets the shadow duty load before the first period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= cfg_q.en;
  end

  assign run = run_q & cfg_q.en & ~unavail_o;

  pwm_sw_prescaler #(
    .S_LOG2_A(S_LOG2_A),
    .S_LOG2_B(S_LOG2_B),
    .S_LOG2_C(S_LOG2_C),
    .S_LOG2_D(S_LOG2_D)
  ) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .slow_clk_i(slow_clk_i),
    .fsel_i    (cfg_q.fsel),
    .tick_o    (tick)
  );

  pwm_sw_core #(
    .CNT_W(CNT_W)
  ) u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_i(tick),
    .duty_i(duty_q),
    .pwm_o (pwm_o),
    .cnt_o (cnt),
    .duty_o(duty_sh),
    .wrap_o(wrap)
  );

  pwm_sw_route #(
    .N_SPDT(N_SPDT)
  ) u_route (
    .en_i      (cfg_q.en),
    .pwm_i     (pwm_o),
    .swa_hi_i  (cfg_q.swa_hi),
    .swa_lo_i  (cfg_q.swa_lo),
    .spd_i     (spd_q),
    .swa_o     (swa_o),
    .swa_vld_o (swa_vld_o),
    .spdt_o    (spdt_o),
    .spdt_vld_o(spdt_vld_o)
  );

endmodule

// File: rtl/pwm_switch_router_chk.sv
module pwm_switch_router_chk #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned N_SPDT = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_q,
  input logic              run,
  input logic              wrap,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  duty_sh,
  input logic              pwm_o,
  input logic              unavail_o,
  input logic              swa_o,
  input logic              swa_vld_o,
  input logic [N_SPDT-1:0] spdt_o,
  input logic [N_SPDT-1:0] spdt_vld_o
);

  // R2
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !pwm_o);

  // R4
  rise_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_o) |-> (cnt == '0));

  // R5
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !wrap) |=> $stable(duty_sh));

  // R6
  unavail_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unavail_o |-> !pwm_o);

  // R9
  swa_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !swa_vld_o |-> !swa_o);

  // R9
  spdt_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spdt_o & ~spdt_vld_o) == '0);

  // R9
  en_off_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (!swa_vld_o && (spdt_vld_o == '0)));

endmodule

bind pwm_switch_router pwm_switch_router_chk #(
  .CNT_W (CNT_W),
  .N_SPDT(N_SPDT)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_q      (cfg_q.en),
  .run       (run),
  .wrap      (wrap),
  .cnt       (cnt),
  .duty_sh   (duty_sh),
  .pwm_o     (pwm_o),
  .unavail_o (unavail_o),
  .swa_o     (swa_o),
  .swa_vld_o (swa_vld_o),
  .spdt_o    (spdt_o),
  .spdt_vld_o(spdt_vld_o)
);

// File: tb/tb_pwm_switch_router.sv
module tb_pwm_switch_router;

  localparam int CLK_PERIOD = 10;
  localparam int SLOW_HALF  = 3 * CLK_PERIOD;
  localparam int SLOW_CYC   = 6;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       slow_clk = 1'b0;
  logic       sleep = 1'b0;
  logic       we = 1'b0;
  logic       en = 1'b0;
  logic [2:0] fsel = '0;
  logic       hi = 1'b0;
  logic       lo = 1'b0;
  logic [1:0] spd = '0;
  logic [7:0] duty = '0;
  logic       pwm, unavail, swa, swa_vld;
  logic [1:0] spdt, spdt_vld;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  pwm_switch_router #(
    .CNT_W(8), .N_SPDT(2),
    .S_LOG2_A(1), .S_LOG2_B(2), .S_LOG2_C(3), .S_LOG2_D(4)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .slow_clk_i(slow_clk), .sleep_i(sleep),
    .cfg_we_i(we), .cfg_en_i(en), .cfg_fsel_i(fsel), .cfg_swa_hi_i(hi),
    .cfg_swa_lo_i(lo), .cfg_spd_i(spd), .cfg_duty_i(duty),
    .pwm_o(pwm), .unavail_o(unavail), .swa_o(swa), .swa_vld_o(swa_vld),
    .spdt_o(spdt), .spdt_vld_o(spdt_vld)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD/4);
    forever #(SLOW_HALF) slow_clk = ~slow_clk;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg(input bit e, input logic [2:0] f, input bit h, input bit l,
                     input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    en = e; fsel = f; hi = h; lo = l; spd = s; duty = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  // count high cycles over n cycles, starting from first run cycle
  task automatic count_high(input int n, output int h);
    h = 0;
    @(posedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm) h++;
    end
  endtask

  // rise-to-rise period and high width, sampled on falling edges
  task automatic measure(output int per, output int h);
    logic prev;
    int guard;
    per = 0; h = 0; guard = 0;
    @(negedge clk);
    prev = pwm;
    while (!(pwm && !prev) && guard < 60000) begin
      prev = pwm; @(negedge clk); guard++;
    end
    per = 1; h = 1; prev = 1'b1;
    while (guard < 60000) begin
      @(negedge clk); guard++;
      if (pwm && !prev) break;
      per++;
      if (pwm) h++;
      prev = pwm;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(pwm == 0 && unavail == 0, "R1", "pwm/unavail after reset", {pwm, unavail}, 0);
    chk(swa == 0 && swa_vld == 0 && spdt == 0 && spdt_vld == 0, "R1",
        "switch lines after reset", {swa, swa_vld, spdt, spdt_vld}, 0);
  endtask

  task automatic t_fast_rates;
    int h;
    cfg(1, 3'd0, 0, 0, 2'b00, 8'd100);
    count_high(256, h);
    chk(h == 100, "R3", "code0 high cycles/period", h, 100);
    cfg(0, 3'd0, 0, 0, 2'b00, 8'd0);
    cfg(1, 3'd1, 0, 0, 2'b00, 8'd100);
    count_high(512, h);
    chk(h == 200, "R3", "code1 high cycles/period", h, 200);
    cfg(0, 3'd0, 0, 0, 2'b00, 8'd0);
    cfg(1, 3'd2, 0, 0, 2'b00, 8'd30);
    count_high(1024, h);
    chk(h == 120, "R3", "code2 high cycles/period", h, 120);
    cfg(0, 3'd0, 0, 0, 2'b00, 8'd0);
  endtask

  task automatic t_duty_edges;
    int h;
    cfg(1, 3'd0, 0, 0, 2'b00, 8'd0);
    count_high(256, h);
    chk(h == 0, "R4", "duty 0 high cycles", h, 0);
    cfg(0, 3'd0, 0, 0, 2'b00, 8'd0);
    cfg(1, 3'd0, 0, 0, 2'b00, 8'd255);
    @(posedge clk);
    @(negedge clk);
    chk(pwm == 1, "R4", "period starts high", pwm, 1);
    h = 1;
    for (int i = 1; i < 256; i++) begin
      @(negedge clk);
      if (pwm) h++;
    end
    chk(h == 255, "R4", "duty 255 high cycles", h, 255);
    cfg(0, 3'd0, 0, 0, 2'b00, 8'd0);
  endtask

  task automatic t_mid_update;
    int h1, h2;
    cfg(1, 3'd0, 0, 0, 2'b00, 8'd200);
    @(posedge clk);
    h1 = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (pwm) h1++;
      if (i == 10) begin duty = 8'd50; we = 1'b1; end
      if (i == 11) we = 1'b0;
    end
    h2 = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (pwm) h2++;
    end
    chk(h1 == 200, "R5", "period with mid write", h1, 200);
    chk(h2 == 50, "R5", "following period", h2, 50);
    cfg(0, 3'd0, 0, 0, 2'b00, 8'd0);
  endtask

  task automatic t_slow_rates;
    int per, h;
    cfg(1, 3'd3, 0, 0, 2'b00, 8'd64);
    measure(per, h);
    chk(per == 256 * SLOW_CYC, "R3", "code3 period", per, 256 * SLOW_CYC);
    chk(h == 64 * SLOW_CYC, "R4", "code3 high", h, 64 * SLOW_CYC);
    cfg(1, 3'd4, 0, 0, 2'b00, 8'd64);
    measure(per, h);
    chk(per == 256 * SLOW_CYC * 2, "R3", "code4 period", per, 256 * SLOW_CYC * 2);
    cfg(1, 3'd7, 0, 0, 2'b00, 8'd8);
    measure(per, h);
    chk(per == 256 * SLOW_CYC * 16, "R3", "code7 period", per, 256 * SLOW_CYC * 16);
    chk(h == 8 * SLOW_CYC * 16, "R4", "code7 high", h, 8 * SLOW_CYC * 16);
    cfg(0, 3'd0, 0, 0, 2'b00, 8'd0);
  endtask

  task automatic t_sleep;
    int h, per;
    sleep = 1'b1;
    cfg(1, 3'd0, 0, 0, 2'b00, 8'd128);
    @(negedge clk);
    chk(unavail == 1, "R6", "unavail flag code0 sleep", unavail, 1);
    h = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (pwm) h++;
    end
    chk(h == 0, "R6", "pwm high cycles in sleep", h, 0);
    cfg(1, 3'd3, 0, 0, 2'b00, 8'd128);
    @(negedge clk);
    chk(unavail == 0, "R6", "unavail flag code3 sleep", unavail, 0);
    measure(per, h);
    chk(per == 256 * SLOW_CYC, "R6", "slow rate runs in sleep", per, 256 * SLOW_CYC);
    sleep = 1'b0;
    cfg(0, 3'd0, 0, 0, 2'b00, 8'd0);
  endtask

  task automatic t_route;
    int bad;
    cfg(1, 3'd0, 1, 0, 2'b01, 8'd100);
    bad = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (swa != pwm || !swa_vld) bad++;
      if (spdt[0] != pwm || spdt_vld != 2'b01 || spdt[1]) bad++;
    end
    chk(bad == 0, "R7", "swa true route + R8 spdt0", bad, 0);
    cfg(1, 3'd0, 0, 1, 2'b10, 8'd100);
    bad = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (swa != !pwm || !swa_vld) bad++;
      if (spdt[1] != pwm || spdt_vld != 2'b10 || spdt[0]) bad++;
    end
    chk(bad == 0, "R7", "swa inverted route + R8 spdt1", bad, 0);
    cfg(1, 3'd0, 1, 1, 2'b00, 8'd100);
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (swa || swa_vld || spdt != 0 || spdt_vld != 0) bad++;
    end
    chk(bad == 0, "R7", "equal selects / R8 spd 0 idle", bad, 0);
  endtask

  task automatic t_disable;
    int bad;
    cfg(0, 3'd0, 1, 0, 2'b11, 8'd100);
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (pwm) bad++;
    end
    chk(bad == 0, "R2", "pwm while disabled", bad, 0);
    chk(swa_vld == 0 && spdt_vld == 0 && swa == 0 && spdt == 0, "R9",
        "valid flags while disabled", {swa_vld, spdt_vld}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_fast_rates();
    t_duty_edges();
    t_mid_update();
    t_slow_rates();
    t_sleep();
    t_route();
    t_disable();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule